// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block turns a stream of instruction bytes into decoded instruction records. Bytes arrive one per valid/ready transfer. The first two bytes of every instruction form a fixed header. The header gives the opcode, the kind of the second operand, the first-operand register and a length code. The length code says how many operand bytes follow: 0, 1, 2, 4, 8 or 16. Once the last byte of an instruction has been taken, the block presents one record on a valid/ready output. The record holds the header fields, the assembled operand, the total instruction size in bytes and a flag for illegal encodings. A core uses the size to advance its instruction pointer.

The datapath is 32 bits wide. Operand bytes are assembled little-endian, and only the lowest four are kept. Longer operands are still consumed in full, so the byte stream stays aligned to instruction boundaries.

Back-pressure works as follows. The input is ready whenever no record is waiting. While a record is valid and `out_ready` is low, the record holds steady and no byte is taken. An input byte is consumed only on a cycle where both `in_valid` and `in_ready` are high. The same rule applies to a record at the output, with `out_valid` and `out_ready`.

Top module: `insn_byte_decoder`

## Requirements
- R1: Header byte 0 carries the opcode in bits 7:2 and the operand kind in bits 1:0. Header byte 1 carries the length code in bits 7:5 and the register number in bits 4:2. Bits 1:0 of byte 1 have no effect on any output.
- R2: Length codes 0, 1, 2, 3, 4 and 5 make the decoder take 0, 1, 2, 4, 8 and 16 operand bytes after the header.
- R3: Operand byte k (counted from 0) lands in `out_operand` bits 8k+7:8k for k below 4. Bytes with k of 4 or more are consumed and discarded.
- R4: For a legal instruction, `out_size` equals 2 plus the number of operand bytes.
- R5: An encoding is illegal if the opcode is above 0x13, the length code is 6 or 7, or the register number is 6 or 7. An illegal encoding gives a record right after its header, with `out_illegal` at 1, `out_size` at 2 and `out_operand` at 0. The next byte after that header is treated as a new header.
- R6: `in_ready` is low exactly while `out_valid` is high. A record that is not accepted keeps all of its fields unchanged until `out_ready` is seen high.
- R7: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded record is valid |
| out_ready | input | 1 | Downstream takes the record |
| out_opcode | output | 6 | Opcode field |
| out_kind | output | 2 | Operand kind (0 immediate, 1 register, 2 memory at immediate, 3 memory at register) |
| out_reg | output | 3 | First-operand register number |
| out_len_code | output | 3 | Raw length code |
| out_operand | output | 32 | Assembled operand, low four bytes |
| out_size | output | 5 | Instruction size in bytes |
| out_illegal | output | 1 | Illegal encoding flag |

## Verification
Two situations are the hardest to reach from the ports. The first is a 16-byte operand that is stalled part way through by input gaps while the output is stalled at the same time; in this case the discarded upper bytes must leave the kept low bytes untouched. The second is an illegal header that is followed at once by a legal instruction, which tests resynchronisation. The stimulus puts every length code and every illegal case into one byte stream. It drives that stream with periodic input gaps and output stalls, including one long output stall. A behavioural parser in the bench walks the same stream to predict each record in order. On every clock the bench also checks the ready/valid relation and that a held record stays stable.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] OPC_LAST = 6'h13;
  localparam logic [2:0] REG_LAST = 3'd5;

  typedef enum logic [1:0] {
    ST_HDR0 = 2'd0,
    ST_HDR1 = 2'd1,
    ST_OPND = 2'd2,
    ST_HOLD = 2'd3
  } dec_state_e;
endpackage

// File: rtl/ibd_len_map.sv
module ibd_len_map #(
  parameter int MAX_OPND_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_OPND_BYTES + 1),
  localparam int MAX_CODE = $clog2(MAX_OPND_BYTES) + 1
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] nbytes,
  output logic             legal
);
  always_comb begin
    legal  = (int'(code) <= MAX_CODE);
    nbytes = '0;
    if (code != 3'd0 && legal)
      nbytes = CNT_W'(1) << (code - 3'd1);
  end

  // R2
  len_pow2_chk: assert property (@(posedge legal) $countones(nbytes) <= 1)
    else $error("length map produced a non power-of-two count");
endmodule

// File: rtl/ibd_operand_acc.sv
module ibd_operand_acc #(
  parameter int DATA_W = 32,
  parameter int MAX_OPND_BYTES = 16,
  localparam int KEEP = DATA_W / ibd_pkg::BYTE_W,
  localparam int CNT_W = $clog2(MAX_OPND_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        byte_in,
  output logic [DATA_W-1:0] acc
);
  for (genvar g = 0; g < KEEP; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        acc[g*8 +: 8] <= '0;
      else if (load && idx == CNT_W'(g))
        acc[g*8 +: 8] <= byte_in;
    end
  end

  // R3
  upper_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && int'(idx) >= KEEP) |=> $stable(acc))
    else $error("upper operand byte changed the kept value");
endmodule

// File: rtl/insn_byte_decoder.sv
module insn_byte_decoder #(
  parameter int DATA_W = 32,
  parameter int MAX_OPND_BYTES = 16,
  localparam int CNT_W = $clog2(MAX_OPND_BYTES + 1),
  localparam int SIZE_W = $clog2(MAX_OPND_BYTES + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [5:0]        out_opcode,
  output logic [1:0]        out_kind,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_len_code,
  output logic [DATA_W-1:0] out_operand,
  output logic [SIZE_W-1:0] out_size,
  output logic              out_illegal
);
  import ibd_pkg::*;

  dec_state_e       state;
  logic [7:0]       hdr0, hdr1;
  logic [CNT_W-1:0] cnt, nbytes_q, nb_in;
  logic             rec_valid, rec_bad, len_ok, hdr_bad, take;

  assign in_ready = (state != ST_HOLD);
  assign take     = in_valid && in_ready;

  ibd_len_map #(.MAX_OPND_BYTES(MAX_OPND_BYTES)) u_len (
    .code(in_byte[7:5]), .nbytes(nb_in), .legal(len_ok)
  );

  assign hdr_bad = !len_ok || (hdr0[7:2] > OPC_LAST) || (in_byte[4:2] > REG_LAST);

  ibd_operand_acc #(.DATA_W(DATA_W), .MAX_OPND_BYTES(MAX_OPND_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .clear(take && state == ST_HDR1),
    .load(take && state == ST_OPND),
    .idx(cnt), .byte_in(in_byte), .acc(out_operand)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HDR0;
      hdr0      <= '0;
      hdr1      <= '0;
      cnt       <= '0;
      nbytes_q  <= '0;
      rec_valid <= 1'b0;
      rec_bad   <= 1'b0;
    end else begin
      case (state)
        ST_HDR0: if (take) begin
          hdr0  <= in_byte;
          state <= ST_HDR1;
        end
        ST_HDR1: if (take) begin
          hdr1     <= in_byte;
          cnt      <= '0;
          nbytes_q <= hdr_bad ? '0 : nb_in;
          rec_bad  <= hdr_bad;
          if (hdr_bad || nb_in == '0) begin
            rec_valid <= 1'b1;
            state     <= ST_HOLD;
          end else begin
            state <= ST_OPND;
          end
        end
        ST_OPND: if (take) begin
          cnt <= cnt + 1'b1;
          if (cnt == nbytes_q - 1'b1) begin
            rec_valid <= 1'b1;
            state     <= ST_HOLD;
          end
        end
        default: if (out_ready) begin
          rec_valid <= 1'b0;
          state     <= ST_HDR0;
        end
      endcase
    end
  end

  assign out_valid    = rec_valid;
  assign out_illegal  = rec_bad;
  assign out_opcode   = hdr0[7:2];
  assign out_kind     = hdr0[1:0];
  assign out_reg      = hdr1[4:2];
  assign out_len_code = hdr1[7:5];
  assign out_size     = SIZE_W'(2) + SIZE_W'(nbytes_q);

  // R6
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !out_valid)
    else $error("input ready overlaps a pending record");

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_operand) &&
      $stable(out_opcode) && $stable(out_size) && $stable(out_illegal)))
    else $error("held record changed");

  // R4
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_size inside {5'd2, 5'd3, 5'd4, 5'd6, 5'd10, 5'd18}))
    else $error("legal record has an impossible size");

  // R5
  illegal_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_size == SIZE_W'(2) && out_operand == '0))
    else $error("illegal record carries operand data");
endmodule

// File: tb/tb_insn_byte_decoder.sv
module tb_insn_byte_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid, out_illegal;
  logic [5:0] out_opcode;
  logic [1:0] out_kind;
  logic [2:0] out_reg, out_len_code;
  logic [31:0] out_operand;
  logic [4:0] out_size;

  always #4 clk = ~clk;

  insn_byte_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_kind(out_kind), .out_reg(out_reg),
    .out_len_code(out_len_code), .out_operand(out_operand),
    .out_size(out_size), .out_illegal(out_illegal)
  );

  int tests = 0, fails = 0;
  logic [7:0] stream[$];
  int e_opc[$], e_kind[$], e_reg[$], e_len[$], e_size[$], e_ill[$];
  logic [31:0] e_opnd[$];

  function automatic int len_bytes(int code);
    if (code == 0) return 0;
    if (code <= 5) return 1 << (code - 1);
    return -1;
  endfunction

  task automatic add_insn(int opc, int kind, int code, int rg, int pad, logic [127:0] val);
    int n;
    stream.push_back(8'((opc << 2) | kind));
    stream.push_back(8'((code << 5) | (rg << 2) | pad));
    n = len_bytes(code);
    if (opc > 8'h13 || rg > 5) n = 0;
    for (int k = 0; k < n; k++) stream.push_back(val[k*8 +: 8]);
  endtask

  task automatic build_expect();
    int i = 0;
    while (i + 1 < stream.size()) begin
      int opc, code, rg, n;
      bit bad;
      logic [31:0] v;
      opc  = int'(stream[i][7:2]);
      code = int'(stream[i+1][7:5]);
      rg   = int'(stream[i+1][4:2]);
      n    = len_bytes(code);
      bad  = (n < 0) || opc > 'h13 || rg > 5;
      if (bad) n = 0;
      v = '0;
      for (int k = 0; k < n && k < 4; k++) v[k*8 +: 8] = stream[i+2+k];
      e_opc.push_back(opc); e_kind.push_back(int'(stream[i][1:0]));
      e_reg.push_back(rg); e_len.push_back(code);
      e_size.push_back(2 + n); e_ill.push_back(bad ? 1 : 0); e_opnd.push_back(v);
      i += 2 + n;
    end
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    logic [127:0] pat = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    int ptr = 0, got = 0, cyc = 0;
    bit prev_hold = 0;
    logic [31:0] p_opnd; logic [5:0] p_opc; logic [4:0] p_size;

    // R1/R2/R3/R4: every length code, varied kinds, registers and padding
    for (int c = 0; c <= 5; c++)
      add_insn(c * 3, c % 4, c, c % 6, (c + 1) % 4, pat ^ {4{32'(c * 32'h01010101)}});
    add_insn(6'h13, 3, 1, 5, 3, 128'hab);            // highest legal opcode and register
    add_insn(6'h14, 0, 2, 0, 0, 128'h0);              // R5 opcode just past the last
    add_insn(6'h02, 1, 6, 4, 1, 128'h0);              // R5 length code 6
    add_insn(6'h05, 2, 7, 1, 2, 128'h0);              // R5 length code 7
    add_insn(6'h0a, 0, 3, 6, 0, 128'h0);              // R5 register 6
    add_insn(6'h3f, 3, 0, 7, 3, 128'h0);              // R5 opcode 0x3f, register 7
    add_insn(6'h0d, 0, 5, 0, 0, ~pat);                // R3 full 16-byte operand after illegal
    add_insn(6'h12, 0, 0, 2, 0, 128'h0);              // R4 bare header
    add_insn(6'h0b, 2, 4, 3, 1, pat);
    add_insn(6'h09, 1, 3, 4, 2, 128'hdeadbeef);
    build_expect();

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);

    while (got < e_opc.size() && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev_hold) begin // R6 held record unchanged
        chk(out_valid && out_operand == p_opnd && out_opcode == p_opc && out_size == p_size,
            "R6", "held record stability", longint'(out_operand), longint'(p_opnd));
      end
      in_valid = (ptr < stream.size()) && (cyc % 7 != 4);
      in_byte  = in_valid ? stream[ptr] : 8'h00;
      out_ready = !(cyc % 4 == 1) && !(cyc >= 60 && cyc < 85);
      #1;
      chk(in_ready == !out_valid, "R6", "in_ready vs out_valid", in_ready, !out_valid);
      if (in_valid && in_ready) ptr++;
      prev_hold = out_valid && !out_ready;
      p_opnd = out_operand; p_opc = out_opcode; p_size = out_size;
      if (out_valid && out_ready) begin
        chk(out_opcode == 6'(e_opc[got]) && out_kind == 2'(e_kind[got]) && out_reg == 3'(e_reg[got]) &&
            out_len_code == 3'(e_len[got]), "R1", "header fields",
            {out_opcode, out_kind, out_reg, out_len_code},
            {6'(e_opc[got]), 2'(e_kind[got]), 3'(e_reg[got]), 3'(e_len[got])});
        chk(out_operand == e_opnd[got], "R3", "operand", out_operand, e_opnd[got]);
        chk(out_size == 5'(e_size[got]), "R2 R4", "size", out_size, e_size[got]);
        chk(out_illegal == 1'(e_ill[got]), "R5", "illegal flag", out_illegal, e_ill[got]);
        got++;
      end
    end
    if (cyc >= 20000) chk(0, "watchdog", "records received", got, e_opc.size());
    @(negedge clk);
    chk(ptr == stream.size(), "R2", "bytes consumed", ptr, stream.size());
    out_ready = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "no extra record", out_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule